// File: doc/BRIEF.md
# SPI Slave Register Bridge

This block lets an external SPI master reach a small on-chip register file and three configuration registers. The link is SPI mode 0 with an active-low select. Bits inside a byte go most significant first. Every protocol field is a 32-bit word carried as four bytes, lowest byte first. The select, clock and data inputs pass through a two-flop synchroniser and are oversampled by the system clock. A byte engine turns the samples into received bytes and shifts reply bytes out on MISO. A frame state machine assembles the bytes into words and decodes each frame.

A frame is everything sent during one select-low period. Its first word is a command:

- A burst write gives a start address and then data words. The address advances by 4 after each data word.
- A configuration write loads one of three configuration registers from the single word that follows.
- A read gives a word count, an address, a dummy word and a start marker, and then clocks the data out.
- A status query returns an identifier in the upper half of the reply and sticky error flags in the lower half.

The frame state machine has ten states:

- CMD: decode the first word.
- WADDR: take the write address.
- WDATA: store data words.
- CDATA: take the configuration value.
- RADDR: take the read address.
- RDUMMY: swallow the dummy word.
- RMARK: check the marker.
- RDATA: shift read words out.
- STAT: shift the status word out.
- SKIP: ignore the rest of the frame.

Its transitions are:

- CMD moves to WADDR, CDATA, RADDR, STAT or SKIP according to the command word.
- The write path runs WADDR to WDATA, and WDATA stays in WDATA.
- CDATA goes to SKIP.
- The read path runs RADDR to RDUMMY to RMARK. RMARK goes to RDATA on a good marker with a legal count, and to SKIP otherwise. RDATA stays in RDATA.
- STAT goes to SKIP, and SKIP stays in SKIP.
- Releasing the select returns any state to CMD.

Top module: `spi_reg_bridge`

## Requirements
- R1: Each 32-bit word is exchanged as four bytes, least significant byte first, with each byte most significant bit first. MOSI is sampled on the rising SCLK edge, and MISO changes only after a falling edge.
- R2: A frame whose command word is 0x00000011 takes the next word as a byte address. Each following data word is written to the register file at that address, and the address then advances by 4. The file has WORDS words at the aligned byte addresses 0 to 4*WORDS-4.
- R3: The command words 0x00010011, 0x00020011 and 0x00030011 load `cfg_a`, `cfg_b` and `cfg_ctrl` respectively from the next word. Any further words in that frame are ignored. All three registers reset to zero.
- R4: A frame whose command has 0x0077 in bits [15:0] takes a word count N from bits [31:16]. It continues with an address, one dummy word and the marker 0x000000AA. After the marker the block returns N words, read from consecutive addresses stepping by 4. An unmapped address reads as zero.
- R5: Command 0x000000FF makes the next word returned equal 0x1608 in bits [31:16] and the flags in the low half. The flag positions are: bit 0 write error, bit 1 write overflow, bit 2 unfinished transfer, bit 8 read error, bit 9 read underflow, bit 10 bad marker. All other bits are zero.
- R6: Flags are sticky and accumulate across frames. They clear only at reset or when a status word has been shifted out completely.
- R7: A data word aimed at an unaligned address, or at an address outside the file, is dropped and sets bit 0.
- R8: Data words beyond MAX_BYTES/4 in one write frame are dropped, and each one sets bit 1.
- R9: Bit 2 is set and the partial word is discarded when the select is released in either case: part-way through a word, or in a write or configuration frame before its first data word.
- R10: A read count of zero, or a count greater than MAX_BYTES/4, sets bit 8, and every word clocked after the marker returns zero.
- R11: Every word clocked after the N requested words returns zero and sets bit 9.
- R12: If the word after the dummy is not 0x000000AA, bit 10 is set and every later word of the frame returns zero.
- R13: An unknown command word makes the rest of the frame have no effect on registers or flags. MISO is held low while the select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| cfg_a | output | 32 | Configuration register A |
| cfg_b | output | 32 | Configuration register B |
| cfg_ctrl | output | 32 | Control configuration register |

## Verification
The bench builds the bridge with WORDS=8 and MAX_BYTES=16, which gives a four-word limit per operation. With that limit, the write overflow, the over-long read count and the edge of the register file can all be reached within a few dozen SPI words. At the default of 60000 bytes these cases would need thousands of words. An SCLK half-period of eight system clocks leaves room for the synchroniser latency, so every returned bit can be compared against a behavioural model of memory, configuration and flags.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic [3:0] {
        ST_CMD, ST_WADDR, ST_WDATA, ST_CDATA, ST_RADDR,
        ST_RDUMMY, ST_RMARK, ST_RDATA, ST_STAT, ST_SKIP
    } frame_state_t;

    localparam logic [31:0] OP_WRITE   = 32'h0000_0011;
    localparam logic [31:0] OP_CFG_A   = 32'h0001_0011;
    localparam logic [31:0] OP_CFG_B   = 32'h0002_0011;
    localparam logic [31:0] OP_CFG_C   = 32'h0003_0011;
    localparam logic [31:0] OP_STATUS  = 32'h0000_00FF;
    localparam logic [31:0] RD_MARKER  = 32'h0000_00AA;
    localparam logic [15:0] OP_READ_LO = 16'h0077;
    localparam logic [15:0] DEV_ID     = 16'h1608;

    // flag vector: [0] wr_err [1] wr_ovf [2] unfinished [3] rd_err [4] rd_under [5] bad_marker
    localparam int NFLAGS = 6;

    function automatic logic [31:0] status_word(input logic [NFLAGS-1:0] f);
        return {DEV_ID, 5'b0, f[5:3], 5'b0, f[2:0]};
    endfunction

endpackage

// File: rtl/srb_spi_phy.sv
module srb_spi_phy #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       cs_end,
    output logic       mid_byte
);
    logic [SYNC_STAGES-1:0] sclk_q, cs_q, mosi_q;
    logic sclk_d, cs_d;
    logic sclk_s, cs_s, mosi_s, sclk_rise, sclk_fall;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sr, tx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
            cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    assign sclk_s    = sclk_q[SYNC_STAGES-1];
    assign cs_s      = cs_q[SYNC_STAGES-1];
    assign mosi_s    = mosi_q[SYNC_STAGES-1];
    assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
    assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;
    assign cs_end    = cs_s & ~cs_d;
    assign mid_byte  = (bit_cnt != 3'd0);
    assign miso      = tx_sr[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else if (cs_s) begin
            bit_cnt  <= '0;
            tx_sr    <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sclk_rise) begin
                rx_sr   <= {rx_sr[6:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sr[6:0], mosi_s};
                end
            end
            if (sclk_fall) begin
                tx_sr <= (bit_cnt == 3'd0) ? tx_byte : {tx_sr[6:0], 1'b0};
            end
        end
    end

    // R1
    byte_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sclk_rise));

    // R13
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_s) |-> !miso);

endmodule

// File: rtl/srb_regfile.sv
module srb_regfile #(
    parameter int WORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output logic        hit,
    output logic [31:0] rdata
);
    localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [31:0]   mem [WORDS];
    logic [IW-1:0] idx;

    assign idx   = addr[IW+1:2];
    assign hit   = (addr[1:0] == 2'b00) && (addr[31:2] < 30'(WORDS));
    assign rdata = hit ? mem[idx] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we && hit) begin
            mem[idx] <= wdata;
        end
    end

    // R7
    wr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> hit);

endmodule

// File: rtl/srb_frame_fsm.sv
module srb_frame_fsm
    import srb_pkg::*;
#(
    parameter int MAX_BYTES = 60000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        cs_end,
    input  logic        mid_byte,
    output logic [7:0]  tx_byte,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_hit,
    input  logic [31:0] bus_rdata,
    output logic [31:0] cfg_a,
    output logic [31:0] cfg_b,
    output logic [31:0] cfg_ctrl
);
    localparam int MAXW = MAX_BYTES / 4;
    localparam int CW   = $clog2(MAXW + 2);

    frame_state_t      state_q, state_d;
    logic [1:0]        byte_idx_q;
    logic [23:0]       word_lo_q;
    logic [31:0]       addr_q, tx_word_q;
    logic [CW-1:0]     wcnt_q;
    logic [15:0]       rcount_q, rleft_q;
    logic [1:0]        cfg_sel_q;
    logic [NFLAGS-1:0] flags_q, flag_set;
    logic              word_done, at_limit, rd_ok, marker_ok, stat_clr, partial;
    logic [31:0]       word_in;

    assign word_done = rx_valid && (byte_idx_q == 2'd3) && !cs_end;
    assign word_in   = {rx_byte, word_lo_q};
    assign at_limit  = (int'(wcnt_q) >= MAXW);
    assign rd_ok     = (rcount_q != 16'd0) && (int'(rcount_q) <= MAXW);
    assign marker_ok = (word_in == RD_MARKER);
    assign stat_clr  = word_done && (state_q == ST_STAT);
    assign partial   = mid_byte || (byte_idx_q != 2'd0);
    assign tx_byte   = 8'(tx_word_q >> {byte_idx_q, 3'b000});

    assign bus_addr  = (state_q == ST_RDATA) ? addr_q + 32'd4 : addr_q;
    assign bus_wdata = word_in;
    assign bus_we    = word_done && (state_q == ST_WDATA) && !at_limit && bus_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CMD;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cs_end) begin
            state_d = ST_CMD;
        end else if (word_done) begin
            unique case (state_q)
                ST_CMD: begin
                    if (word_in == OP_WRITE)                          state_d = ST_WADDR;
                    else if (word_in == OP_CFG_A || word_in == OP_CFG_B ||
                             word_in == OP_CFG_C)                     state_d = ST_CDATA;
                    else if (word_in[15:0] == OP_READ_LO)             state_d = ST_RADDR;
                    else if (word_in == OP_STATUS)                    state_d = ST_STAT;
                    else                                              state_d = ST_SKIP;
                end
                ST_WADDR:  state_d = ST_WDATA;
                ST_WDATA:  state_d = ST_WDATA;
                ST_CDATA:  state_d = ST_SKIP;
                ST_RADDR:  state_d = ST_RDUMMY;
                ST_RDUMMY: state_d = ST_RMARK;
                ST_RMARK:  state_d = (marker_ok && rd_ok) ? ST_RDATA : ST_SKIP;
                ST_RDATA:  state_d = ST_RDATA;
                ST_STAT:   state_d = ST_SKIP;
                ST_SKIP:   state_d = ST_SKIP;
                default:   state_d = ST_CMD;
            endcase
        end
    end

    // flag events
    always_comb begin
        flag_set = '0;
        if (word_done && state_q == ST_WDATA) begin
            flag_set[0] = !at_limit && !bus_hit;
            flag_set[1] = at_limit;
        end
        flag_set[2] = cs_end && (partial || state_q == ST_WADDR || state_q == ST_CDATA ||
                                 (state_q == ST_WDATA && wcnt_q == '0));
        if (word_done && state_q == ST_RMARK) begin
            flag_set[3] = marker_ok && !rd_ok;
            flag_set[5] = !marker_ok;
        end
        flag_set[4] = word_done && (state_q == ST_RDATA) && (rleft_q == 16'd0);
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_idx_q <= '0;
            word_lo_q  <= '0;
            addr_q     <= '0;
            tx_word_q  <= '0;
            wcnt_q     <= '0;
            rcount_q   <= '0;
            rleft_q    <= '0;
            cfg_sel_q  <= '0;
            flags_q    <= '0;
            cfg_a      <= '0;
            cfg_b      <= '0;
            cfg_ctrl   <= '0;
        end else begin
            flags_q <= (stat_clr ? '0 : flags_q) | flag_set;
            if (cs_end) begin
                byte_idx_q <= '0;
                tx_word_q  <= '0;
            end else if (rx_valid) begin
                byte_idx_q <= byte_idx_q + 2'd1;
                word_lo_q  <= {rx_byte, word_lo_q[23:8]};
            end
            if (word_done) begin
                unique case (state_q)
                    ST_CMD: begin
                        tx_word_q <= (word_in == OP_STATUS) ? status_word(flags_q) : '0;
                        rcount_q  <= word_in[31:16];
                        cfg_sel_q <= word_in[17:16];
                    end
                    ST_WADDR: begin
                        addr_q <= word_in;
                        wcnt_q <= '0;
                    end
                    ST_WDATA: begin
                        if (!at_limit) begin
                            wcnt_q <= wcnt_q + 1'b1;
                            addr_q <= addr_q + 32'd4;
                        end
                    end
                    ST_CDATA: begin
                        unique case (cfg_sel_q)
                            2'd1:    cfg_a    <= word_in;
                            2'd2:    cfg_b    <= word_in;
                            2'd3:    cfg_ctrl <= word_in;
                            default: ;
                        endcase
                    end
                    ST_RADDR: addr_q <= word_in;
                    ST_RMARK: begin
                        if (marker_ok && rd_ok) begin
                            tx_word_q <= bus_rdata;
                            rleft_q   <= rcount_q;
                        end else begin
                            tx_word_q <= '0;
                        end
                    end
                    ST_RDATA: begin
                        if (rleft_q != 16'd0) rleft_q <= rleft_q - 16'd1;
                        if (rleft_q > 16'd1) begin
                            addr_q    <= addr_q + 32'd4;
                            tx_word_q <= bus_rdata;
                        end else begin
                            tx_word_q <= '0;
                        end
                    end
                    default: tx_word_q <= '0;
                endcase
            end
        end
    end

    // R6
    sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags_q) & ~flags_q)) |-> $past(stat_clr));

    // R13
    release_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_end |=> state_q == ST_CMD);

    // R12
    skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> tx_word_q == '0);

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> addr_q == $past(addr_q) + 32'd4);

    // R8
    write_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wcnt_q) <= MAXW);

endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge #(
    parameter int WORDS       = 16,
    parameter int MAX_BYTES   = 60000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic [31:0] cfg_a,
    output logic [31:0] cfg_b,
    output logic [31:0] cfg_ctrl
);
    logic        rx_valid, cs_end, mid_byte, bus_we, bus_hit;
    logic [7:0]  rx_byte, tx_byte;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    srb_spi_phy #(.SYNC_STAGES(SYNC_STAGES)) u_phy (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .tx_byte(tx_byte), .miso(spi_miso), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cs_end(cs_end), .mid_byte(mid_byte)
    );

    srb_frame_fsm #(.MAX_BYTES(MAX_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cs_end(cs_end), .mid_byte(mid_byte), .tx_byte(tx_byte),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_hit(bus_hit), .bus_rdata(bus_rdata),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_ctrl(cfg_ctrl)
    );

    srb_regfile #(.WORDS(WORDS)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .hit(bus_hit), .rdata(bus_rdata)
    );

endmodule

// File: tb/sim_spi_reg_bridge.sv
`timescale 1ns/1ps
module sim_spi_reg_bridge;
    localparam int WORDS = 8;
    localparam int MAX_BYTES = 16;
    localparam int MAXW = MAX_BYTES / 4;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [31:0] cfg_a, cfg_b, cfg_ctrl;

    always #2 clk = ~clk;

    spi_reg_bridge #(.WORDS(WORDS), .MAX_BYTES(MAX_BYTES), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_ctrl(cfg_ctrl)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [31:0] m_mem [WORDS];
    logic [31:0] m_cfg [3];
    logic [15:0] m_flags = 16'h0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic half_bit();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer_byte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = t[i];
            half_bit();
            r[i] = miso;
            sclk = 1'b1;
            half_bit();
            sclk = 1'b0;
        end
    endtask

    task automatic xfer_word(input logic [31:0] w, output logic [31:0] r);
        for (int b = 0; b < 4; b++) begin
            logic [7:0] rb;
            xfer_byte(w[8*b +: 8], rb);
            r[8*b +: 8] = rb;
        end
    endtask

    task automatic begin_frame();
        @(negedge clk);
        cs_n = 1'b0;
        half_bit();
    endtask

    task automatic end_frame();
        half_bit();
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (4) half_bit();
    endtask

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (a[1:0] == 2'b00 && a < 32'(WORDS * 4)) return m_mem[a >> 2];
        return 32'h0;
    endfunction

    task automatic write_frame(input logic [31:0] addr, input int n, input logic [31:0] seed);
        logic [31:0] r, a, d;
        a = addr;
        begin_frame();
        xfer_word(32'h0000_0011, r);
        xfer_word(addr, r);
        for (int i = 0; i < n; i++) begin
            d = seed + 32'(i) * 32'h0103_0507;
            xfer_word(d, r);
            if (i >= MAXW) m_flags |= 16'h0002;
            else begin
                if (a[1:0] == 2'b00 && a < 32'(WORDS * 4)) m_mem[a >> 2] = d;
                else m_flags |= 16'h0001;
                a += 32'd4;
            end
        end
        end_frame();
    endtask

    task automatic cfg_frame(input string tag, input logic [31:0] cmd, input int sel,
                             input logic [31:0] data, input bit extra);
        logic [31:0] r;
        begin_frame();
        xfer_word(cmd, r);
        xfer_word(data, r);
        if (extra) xfer_word(32'hFFFF_FFFF, r);
        end_frame();
        m_cfg[sel] = data;
        check({tag, " cfg_a"}, cfg_a, m_cfg[0]);
        check({tag, " cfg_b"}, cfg_b, m_cfg[1]);
        check({tag, " cfg_ctrl"}, cfg_ctrl, m_cfg[2]);
    endtask

    task automatic read_frame(input string tag, input logic [15:0] cnt, input logic [31:0] addr,
                              input logic [31:0] marker, input int nclk);
        logic [31:0] r, exp;
        begin_frame();
        xfer_word({cnt, 16'h0077}, r);
        xfer_word(addr, r);
        xfer_word(32'h0, r);
        xfer_word(marker, r);
        if (marker != 32'hAA) m_flags |= 16'h0400;
        else if (cnt == 0 || int'(cnt) > MAXW) m_flags |= 16'h0100;
        for (int i = 0; i < nclk; i++) begin
            xfer_word(32'h0, r);
            if (marker != 32'hAA || cnt == 0 || int'(cnt) > MAXW) exp = 32'h0;
            else if (i < int'(cnt)) exp = mem_rd(addr + 32'(4 * i));
            else begin
                exp = 32'h0;
                m_flags |= 16'h0200;
            end
            check(tag, r, exp);
        end
        end_frame();
    endtask

    task automatic status_frame(input string tag);
        logic [31:0] r;
        begin_frame();
        xfer_word(32'h0000_00FF, r);
        xfer_word(32'h0, r);
        end_frame();
        check(tag, r, {16'h1608, m_flags});
        m_flags = 16'h0;
    endtask

    initial begin
        logic [31:0] r;
        logic [7:0] rb;
        for (int i = 0; i < WORDS; i++) m_mem[i] = 32'h0;
        for (int i = 0; i < 3; i++) m_cfg[i] = 32'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R3 reset values, R13 idle line
        check("R3 reset cfg_a", cfg_a, 32'h0);
        check("R3 reset cfg_b", cfg_b, 32'h0);
        check("R3 reset cfg_ctrl", cfg_ctrl, 32'h0);
        check("R13 idle miso", {31'h0, miso}, 32'h0);
        // R1 R5: byte order visible in the status reply
        status_frame("R5 R1 reset status");
        cfg_frame("R3 ctrl", 32'h0003_0011, 2, 32'h0000_0008, 1'b0);
        cfg_frame("R3 a with extra word", 32'h0001_0011, 0, 32'hA5A5_0001, 1'b1);
        cfg_frame("R3 b", 32'h0002_0011, 1, 32'h5A5A_0002, 1'b0);
        // R2 R4 burst
        write_frame(32'h0, 4, 32'h1122_3344);
        read_frame("R4 R2 burst read", 16'd4, 32'h0, 32'hAA, 4);
        read_frame("R4 single read", 16'd1, 32'h8, 32'hAA, 1);
        // R7
        write_frame(32'h40, 1, 32'hDEAD_0000);
        status_frame("R7 unmapped write");
        status_frame("R6 flags cleared");
        // R8
        write_frame(32'h0C, 5, 32'h0BAD_0000);
        read_frame("R8 dropped word", 16'd1, 32'h1C, 32'hAA, 1);
        read_frame("R8 R2 kept words", 16'd4, 32'h0C, 32'hAA, 4);
        status_frame("R8 overflow flag");
        // R10
        read_frame("R10 zero count", 16'd0, 32'h0, 32'hAA, 1);
        status_frame("R10 zero count flag");
        read_frame("R10 over limit", 16'd5, 32'h0, 32'hAA, 2);
        status_frame("R10 over limit flag");
        // R11
        read_frame("R11 beyond count", 16'd1, 32'h4, 32'hAA, 3);
        status_frame("R11 underflow flag");
        // R12
        read_frame("R12 bad marker", 16'd1, 32'h0, 32'hAB, 2);
        status_frame("R12 marker flag");
        // R9 mid-word release
        begin_frame();
        xfer_byte(8'h11, rb);
        xfer_byte(8'h00, rb);
        end_frame();
        m_flags |= 16'h0004;
        status_frame("R9 mid word release");
        // R9 write without data
        begin_frame();
        xfer_word(32'h0000_0011, r);
        xfer_word(32'h0, r);
        end_frame();
        m_flags |= 16'h0004;
        status_frame("R9 write without data");
        // R13 unknown command
        begin_frame();
        xfer_word(32'h1234_5678, r);
        xfer_word(32'h0001_0011, r);
        xfer_word(32'hCAFE_F00D, r);
        end_frame();
        check("R13 cfg_a kept", cfg_a, m_cfg[0]);
        check("R13 idle miso after frame", {31'h0, miso}, 32'h0);
        status_frame("R13 no flags");
        read_frame("R13 memory kept", 16'd4, 32'h0, 32'hAA, 4);
        // R6 accumulation
        write_frame(32'h22, 1, 32'h7777_0000);
        read_frame("R6 underflow part", 16'd1, 32'h0, 32'hAA, 2);
        status_frame("R6 accumulated flags");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule